// File: doc/BRIEF.md
# Dual-Clock Fall-Through FIFO

This block moves data words from one clock domain to an unrelated second clock domain. The write side pushes a word on any write-clock edge where the write enable is high and the input-ready flag is active. The read side needs no request to fetch data. The oldest stored word is loaded into a registered output stage and announced by the output-ready flag. A read enable on a read-clock edge while output-ready is active consumes that word and lets the next one fall through. The output stage acts as one extra storage slot, so the block holds 2^ADDR_W + 1 words in total.

Pointers travel between the domains as Gray code through two-flop synchronizers. Each domain computes its own flags only from pointers it holds locally:

- The write domain produces input-ready, almost-full and half-full.
- The read domain produces output-ready and almost-empty.

All flags are active low. A flag reacts to activity on the other side only after the synchronizer delay. Two offset inputs set the almost-full and almost-empty thresholds, and they are captured while reset is asserted. The single active-high reset is synchronous and must be held for several edges of both clocks.

Top module: `fwft_fifo`

## Requirements
- R1: Capacity D is 2^ADDR_W + 1 words. `ir_n` is high once D words are held. A write while `ir_n` is high is dropped, and no stored word is overwritten. `ir_n` returns low after a read frees space, once the freed location has crossed the synchronizer.
- R2: Without any read request, the oldest word appears on `dout` with `or_n` low. It stays there unchanged while `rd_en` is low, and words leave in the order they were written.
- R3: A read-clock edge with `rd_en` high and `or_n` low consumes the presented word. A read while `or_n` is high is ignored, so the next written word is still delivered.
- R4: `hf_n` is low when the stored count is at least 2^(ADDR_W-1) + 2, and high below that count.
- R5: `paf_n` is low when the stored count is at least D − m, where m is `af_off`. It is high below that count.
- R6: `pae_n` is low when the stored count is at most n, where n is `ae_off`. It is high above that count.
- R7: While reset is applied and after it is released: `ir_n` = 0, `or_n` = 1, `pae_n` = 0, `paf_n` = 1, `hf_n` = 1.
- R8: Pointers cross the clock domains in Gray code and change one bit per step. A stream with concurrent writes and reads on unrelated clocks arrives complete and in order.
- R9: `af_off` and `ae_off` are captured only during reset. Changing them afterwards does not move the thresholds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write clock |
| rclk | input | 1 | Read clock |
| rst | input | 1 | Synchronous active-high reset, held across edges of both clocks |
| af_off | input | ADDR_W+1 | Almost-full offset m, captured during reset |
| ae_off | input | ADDR_W+1 | Almost-empty offset n, captured during reset |
| wr_en | input | 1 | Write request, sampled on rising `wclk` |
| din | input | DATA_W | Write data |
| ir_n | output | 1 | Input ready, active low |
| paf_n | output | 1 | Almost full, active low |
| hf_n | output | 1 | Half full, active low |
| rd_en | input | 1 | Read request, sampled on rising `rclk` |
| dout | output | DATA_W | Oldest stored word |
| or_n | output | 1 | Output ready, active low |
| pae_n | output | 1 | Almost empty, active low |

## Verification
The bench builds the block with ADDR_W = 3 and DATA_W = 8, which gives a total depth of nine words. It captures offsets m = 2 and n = 2 at reset. With these values, full, half-full (6 words), almost-full (7 words) and almost-empty (2 words or fewer) are all reached within a few writes. Every fill level from empty to full can therefore be checked in both directions. A 10 ns write clock against a 12 ns read clock makes the edge alignment drift, which exercises the pointer crossing under changing phase.

// File: rtl/fwft_pkg.sv
package fwft_pkg;

  localparam int SYNC_STAGES = 2;

  function automatic logic [31:0] bin2gray(input logic [31:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [31:0] gray2bin(input logic [31:0] g);
    logic [31:0] b;
    b = g;
    for (int s = 1; s < 32; s = s << 1) b = b ^ (b >> s);
    return b;
  endfunction

endpackage

// File: rtl/fwft_ram.sv
module fwft_ram #(
  parameter int DATA_W = 36,
  parameter int ADDR_W = 9
) (
  input  logic              wclk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              rclk,
  input  logic              re,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge wclk) begin
    if (we) mem[waddr] <= wdata;
  end

  // The registered read port doubles as the fall-through output stage.
  always_ff @(posedge rclk) begin
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/fwft_sync.sv
module fwft_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '0;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/fwft_wr_ctrl.sv
module fwft_wr_ctrl
  import fwft_pkg::*;
#(
  parameter int ADDR_W = 9
) (
  input  logic              wclk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W:0]   af_off,
  input  logic [ADDR_W:0]   rgray_s,
  output logic [ADDR_W:0]   wgray,
  output logic [ADDR_W-1:0] waddr,
  output logic              we,
  output logic              ir_n,
  output logic              paf_n,
  output logic              hf_n
);
  localparam int PW = ADDR_W + 1;
  localparam logic [PW-1:0] DEPTH    = PW'(1 << ADDR_W);
  // The output stage holds one word, so RAM thresholds sit one below the totals.
  localparam logic [PW-1:0] HALF_RAM = PW'((1 << (ADDR_W - 1)) + 1);

  logic [PW-1:0] wbin, wbin_nxt, rbin, lvl_nxt, lvl_now, m_q;
  logic [PW:0]   af_thr;

  assign rbin     = PW'(gray2bin(32'(rgray_s)));
  assign we       = wr_en && !ir_n;
  assign wbin_nxt = wbin + PW'(we);
  assign lvl_nxt  = wbin_nxt - rbin;
  assign lvl_now  = wbin - rbin;
  assign af_thr   = {1'b0, DEPTH} - {1'b0, m_q};
  assign waddr    = wbin[ADDR_W-1:0];

  always_ff @(posedge wclk) begin
    if (rst) begin
      wbin  <= '0;
      wgray <= '0;
      ir_n  <= 1'b0;
      paf_n <= 1'b1;
      hf_n  <= 1'b1;
      m_q   <= af_off;
    end else begin
      wbin  <= wbin_nxt;
      wgray <= PW'(bin2gray(32'(wbin_nxt)));
      ir_n  <= (lvl_nxt == DEPTH);
      paf_n <= !({1'b0, lvl_nxt} >= af_thr);
      hf_n  <= !(lvl_nxt >= HALF_RAM);
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge wclk) disable iff (rst)
    lvl_now <= DEPTH);  // R1
  AST_FULL_DROPS_WRITE: assert property (@(posedge wclk) disable iff (rst)
    (ir_n && wr_en) |=> $stable(wbin));  // R1
  AST_FULL_FLAGGED: assert property (@(posedge wclk) disable iff (rst)
    (lvl_now == DEPTH) |-> ir_n);  // R1
  AST_WGRAY_ONE_BIT: assert property (@(posedge wclk) disable iff (rst)
    $countones(wgray ^ $past(wgray)) <= 1);  // R8
endmodule

// File: rtl/fwft_rd_ctrl.sv
module fwft_rd_ctrl
  import fwft_pkg::*;
#(
  parameter int ADDR_W = 9
) (
  input  logic              rclk,
  input  logic              rst,
  input  logic              rd_en,
  input  logic [ADDR_W:0]   ae_off,
  input  logic [ADDR_W:0]   wgray_s,
  output logic [ADDR_W:0]   fgray,
  output logic [ADDR_W-1:0] raddr,
  output logic              re,
  output logic              or_n,
  output logic              pae_n
);
  localparam int PW = ADDR_W + 1;
  localparam logic [PW-1:0] DEPTH = PW'(1 << ADDR_W);

  logic [PW-1:0] fbin, fbin_nxt, wbin_s, ram_lvl, n_q;
  logic [PW:0]   total_nxt;
  logic          ov, ov_nxt, consume, fetch;

  assign wbin_s    = PW'(gray2bin(32'(wgray_s)));
  assign ov        = !or_n;
  assign ram_lvl   = wbin_s - fbin;
  assign consume   = rd_en && ov;
  assign fetch     = (ram_lvl != '0) && (!ov || consume);
  assign fbin_nxt  = fbin + PW'(fetch);
  assign ov_nxt    = fetch || (ov && !consume);
  assign total_nxt = {1'b0, wbin_s - fbin_nxt} + (PW+1)'(ov_nxt);
  assign re        = fetch;
  assign raddr     = fbin[ADDR_W-1:0];

  always_ff @(posedge rclk) begin
    if (rst) begin
      fbin  <= '0;
      fgray <= '0;
      or_n  <= 1'b1;
      pae_n <= 1'b0;
      n_q   <= ae_off;
    end else begin
      fbin  <= fbin_nxt;
      fgray <= PW'(bin2gray(32'(fbin_nxt)));
      or_n  <= !ov_nxt;
      pae_n <= !(total_nxt <= {1'b0, n_q});
    end
  end

  AST_NO_UNDERFLOW: assert property (@(posedge rclk) disable iff (rst)
    ram_lvl <= DEPTH);  // R8
  AST_FETCH_PRESENTS: assert property (@(posedge rclk) disable iff (rst)
    re |=> !or_n);  // R2
  AST_EMPTY_READ_IGNORED: assert property (@(posedge rclk) disable iff (rst)
    (or_n && rd_en && ram_lvl == '0) |=> $stable(fbin));  // R3
  AST_FGRAY_ONE_BIT: assert property (@(posedge rclk) disable iff (rst)
    $countones(fgray ^ $past(fgray)) <= 1);  // R8
endmodule

// File: rtl/fwft_fifo.sv
module fwft_fifo
  import fwft_pkg::*;
#(
  parameter int DATA_W = 36,
  parameter int ADDR_W = 9
) (
  input  logic              wclk,
  input  logic              rclk,
  input  logic              rst,
  input  logic [ADDR_W:0]   af_off,
  input  logic [ADDR_W:0]   ae_off,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] din,
  output logic              ir_n,
  output logic              paf_n,
  output logic              hf_n,
  input  logic              rd_en,
  output logic [DATA_W-1:0] dout,
  output logic              or_n,
  output logic              pae_n
);
  localparam int PW = ADDR_W + 1;

  logic [PW-1:0]     wgray, wgray_s, fgray, fgray_s;
  logic [ADDR_W-1:0] waddr, raddr;
  logic              we, re;

  fwft_wr_ctrl #(.ADDR_W(ADDR_W)) u_wr (
    .wclk(wclk), .rst(rst), .wr_en(wr_en), .af_off(af_off),
    .rgray_s(fgray_s), .wgray(wgray), .waddr(waddr), .we(we),
    .ir_n(ir_n), .paf_n(paf_n), .hf_n(hf_n)
  );

  fwft_rd_ctrl #(.ADDR_W(ADDR_W)) u_rd (
    .rclk(rclk), .rst(rst), .rd_en(rd_en), .ae_off(ae_off),
    .wgray_s(wgray_s), .fgray(fgray), .raddr(raddr), .re(re),
    .or_n(or_n), .pae_n(pae_n)
  );

  fwft_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_w2r (
    .clk(rclk), .rst(rst), .d(wgray), .q(wgray_s)
  );

  fwft_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_r2w (
    .clk(wclk), .rst(rst), .d(fgray), .q(fgray_s)
  );

  fwft_ram #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_ram (
    .wclk(wclk), .we(we), .waddr(waddr), .wdata(din),
    .rclk(rclk), .re(re), .raddr(raddr), .rdata(dout)
  );

  AST_WORD_HELD: assert property (@(posedge rclk) disable iff (rst)
    (!or_n && !rd_en) |=> (!or_n && $stable(dout)));  // R2
endmodule

// File: tb/fwft_fifo_bench.sv
`timescale 1ns/1ps
module fwft_fifo_bench;
  localparam int DW = 8;
  localparam int AW = 3;
  localparam int D  = (1 << AW) + 1;
  localparam int M  = 2;
  localparam int N  = 2;

  logic wclk = 1'b0, rclk = 1'b0, rst = 1'b1;
  logic [AW:0] af_off = AW'(M), ae_off = AW'(N);
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [DW-1:0] din = '0;
  logic [DW-1:0] dout;
  logic ir_n, paf_n, hf_n, or_n, pae_n;

  int n_chk = 0, n_fail = 0;
  logic [DW-1:0] mq[$];

  always #5 wclk = ~wclk;
  always #6 rclk = ~rclk;

  fwft_fifo #(.DATA_W(DW), .ADDR_W(AW)) u_fwft_fifo (
    .wclk(wclk), .rclk(rclk), .rst(rst), .af_off(af_off), .ae_off(ae_off),
    .wr_en(wr_en), .din(din), .ir_n(ir_n), .paf_n(paf_n), .hf_n(hf_n),
    .rd_en(rd_en), .dout(dout), .or_n(or_n), .pae_n(pae_n)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  task automatic settle();
    repeat (10) @(negedge wclk);
  endtask

  task automatic push(input logic [DW-1:0] v);
    @(negedge wclk);
    wr_en = 1'b1;
    din   = v;
    if (!ir_n) mq.push_back(v);
    @(negedge wclk);
    wr_en = 1'b0;
  endtask

  task automatic push_wait(input logic [DW-1:0] v);
    @(negedge wclk);
    while (ir_n) @(negedge wclk);
    wr_en = 1'b1;
    din   = v;
    mq.push_back(v);
    @(negedge wclk);
    wr_en = 1'b0;
  endtask

  task automatic pop_chk(input string tag);
    logic [DW-1:0] e;
    @(negedge rclk);
    if (or_n || mq.size() == 0) begin
      chk({tag, " word present"}, {31'd0, or_n}, 32'd0);
    end else begin
      e = mq.pop_front();
      chk(tag, 32'(dout), 32'(e));
      rd_en = 1'b1;
      @(negedge rclk);
      rd_en = 1'b0;
    end
  endtask

  task automatic level_flags(input int cnt);
    chk($sformatf("R4 hf_n at %0d", cnt), {31'd0, hf_n}, (cnt >= (1 << (AW-1)) + 2) ? 32'd0 : 32'd1);
    chk($sformatf("R5 paf_n at %0d", cnt), {31'd0, paf_n}, (cnt >= D - M) ? 32'd0 : 32'd1);
    chk($sformatf("R6 pae_n at %0d", cnt), {31'd0, pae_n}, (cnt <= N) ? 32'd0 : 32'd1);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(negedge wclk);
    chk("R7 ir_n in reset", {31'd0, ir_n}, 32'd0);
    chk("R7 or_n in reset", {31'd0, or_n}, 32'd1);
    repeat (5) @(negedge wclk);
    rst = 1'b0;
    @(negedge wclk);
    chk("R7 ir_n", {31'd0, ir_n}, 32'd0);
    chk("R7 or_n", {31'd0, or_n}, 32'd1);
    chk("R7 pae_n", {31'd0, pae_n}, 32'd0);
    chk("R7 paf_n", {31'd0, paf_n}, 32'd1);
    chk("R7 hf_n", {31'd0, hf_n}, 32'd1);
  endtask

  task automatic t_fall_through();
    push(8'hA5);
    settle();
    chk("R2 or_n after write", {31'd0, or_n}, 32'd0);
    chk("R2 dout without read", 32'(dout), 32'hA5);
    settle();
    chk("R2 word held", 32'(dout), 32'hA5);
    pop_chk("R3 consume first");
    settle();
    chk("R3 or_n after last read", {31'd0, or_n}, 32'd1);
  endtask

  task automatic t_empty_read();
    @(negedge rclk);
    rd_en = 1'b1;
    repeat (5) @(negedge rclk);
    rd_en = 1'b0;
    push(8'h3C);
    settle();
    chk("R3 ignored empty read keeps next word", 32'(dout), 32'h3C);
    pop_chk("R3 read after empty reads");
    settle();
  endtask

  task automatic t_levels();
    af_off = '0;
    ae_off = '0;
    for (int c = 1; c < D; c++) begin
      push(8'(8'h10 + c));
      settle();
      level_flags(c);
    end
    chk("R9 offsets kept after reset", {31'd0, paf_n}, 32'd0);
    for (int c = D - 2; c >= 0; c--) begin
      pop_chk("R2 order while draining");
      settle();
      level_flags(c);
    end
  endtask

  task automatic t_full();
    int acc = 0;
    logic [DW-1:0] nv = 8'h80;
    for (int i = 0; i < 30; i++) begin
      @(negedge wclk);
      wr_en = 1'b1;
      din   = nv;
      if (!ir_n) begin
        mq.push_back(nv);
        nv++;
        acc++;
      end
    end
    @(negedge wclk);
    wr_en = 1'b0;
    chk("R1 words accepted up to depth", 32'(acc), 32'(D));
    chk("R1 ir_n when full", {31'd0, ir_n}, 32'd1);
    level_flags(D);
    for (int i = 0; i < 3; i++) push(8'hEE);
    settle();
    pop_chk("R1 oldest after dropped writes");
    settle();
    chk("R1 ir_n after read frees slot", {31'd0, ir_n}, 32'd0);
    for (int i = 0; i < D - 1; i++) pop_chk("R1 no overwrite");
    settle();
    chk("R1 empty after drain", {31'd0, or_n}, 32'd1);
  endtask

  task automatic t_stream();
    fork
      for (int i = 0; i < 40; i++) push_wait(8'(8'h40 + i));
      for (int i = 0; i < 40; i++) begin
        @(negedge rclk);
        while (or_n) @(negedge rclk);
        pop_chk("R8 concurrent stream order");
      end
    join
    settle();
    chk("R8 empty after stream", {31'd0, or_n}, 32'd1);
  endtask

  initial begin
    #1_000_000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    t_reset();
    t_fall_through();
    t_empty_read();
    t_levels();
    t_full();
    t_stream();
    report();
  end
endmodule